// File: doc/BRIEF.md
# Byte EEPROM Access Engine with Burst Loader

This block drives an external byte-wide EEPROM through a parallel request/acknowledge port. A host reaches it through four small registers: a control word, an EEPROM address, a data byte and a memory base. The host uses the control word to move one byte between the data register and the EEPROM location named by the address register. It can also launch a burst loader. The loader walks the EEPROM and copies records of bytes into a 24-bit internal memory space through a plain byte write port.

A burst record starts with a 16-bit target field, low byte first. A count byte follows, and after it that many data bytes. The data bytes go to consecutive target locations. A record whose count is zero ends the burst. Each target address joins the 9-bit base register, which gives the upper bits, to the low 15 bits of the record's field. Bit 15 of the field plays no part. A burst that follows reset with no earlier operation reads from EEPROM address 0. Every other burst resumes one past the last EEPROM byte touched.

Top module: `nvm_burst_loader`

## Requirements
- R1: After reset every register reads 0, ee_req is low and mem_valid is low.
- R2: Writing control bit 1 starts a single read of the EEPROM at the address register. The byte lands in the data register, and bit 1 reads 1 until the byte is there, then 0.
- R3: Writing control bit 0 writes the data register's byte to the EEPROM at the address register. Bit 0 reads 1 until the EEPROM acknowledges, then 0.
- R4: Writing control bit 2 starts a burst. Records (target low byte, target high byte, count, data bytes) are read in turn until a count of 0, then bit 2 reads 0.
- R5: The first burst after reset with no earlier operation begins at EEPROM address 0. Any later burst begins at the address after the last one accessed, modulo 2^16.
- R6: Each burst data byte is written to mem_addr = {base[8:0], field[14:0]}, ignoring field bit 15. The low 15 bits advance by one per byte and wrap inside the 15-bit window.
- R7: Control bit 3 reads 1 while any operation runs. Host writes to any register during that time are ignored.
- R8: When several control request bits are written together, read wins over write, and write wins over burst. Only one operation runs.
- R9: ee_req stays high with stable ee_addr, ee_we and ee_wdata until ee_ack.
- R10: Register offsets are control 0, address 1, data 2, base 3. The address is 16 bits, the data 8 bits and the base 9 bits. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Host write register offset |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 2 | Host read register offset |
| rd_data | output | 32 | Registered readback, one cycle after rd_addr |
| ee_req | output | 1 | EEPROM request |
| ee_we | output | 1 | EEPROM request is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | EEPROM acknowledge, one cycle |
| ee_rdata | input | 8 | EEPROM read byte, valid with ee_ack |
| mem_valid | output | 1 | Internal memory byte write strobe |
| mem_addr | output | 24 | Internal memory byte address |
| mem_data | output | 8 | Internal memory byte |

## Verification
The bench builds the block with its default parameters: a 16-bit EEPROM address, a 24-bit target space and a 9-bit base. With these values the address wrap at 0xFFFF and the 15-bit window wrap at 0x7FFF are each reached after only a handful of bytes. An EEPROM model whose acknowledge delay is swept from 0 to 3 cycles runs single reads, single writes and chained bursts. The bench computes every target address arithmetically from the base and the record field, and it checks where each burst starts from the sequence of earlier operations.

// File: rtl/nvm_loader_pkg.sv
package nvm_loader_pkg;
  typedef enum logic [1:0] {OP_RD, OP_WR, OP_BURST} op_e;
  typedef enum logic [2:0] {S_IDLE, S_ONE, S_ALO, S_AHI, S_CNT, S_DAT} st_e;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_BASE = 2'd3;
endpackage

// File: rtl/nvm_regs.sv
module nvm_regs
  import nvm_loader_pkg::*;
#(
  parameter int HW = 32,
  parameter int EE_AW = 16,
  parameter int DW = 8,
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [HW-1:0]     wr_data,
  input  logic [1:0]        rd_addr,
  output logic [HW-1:0]     rd_data,
  input  logic              busy,
  input  logic              act_rd,
  input  logic              act_wr,
  input  logic              act_burst,
  input  logic              dat_ld,
  input  logic [DW-1:0]     dat_val,
  output logic              start,
  output op_e               start_op,
  output logic [EE_AW-1:0]  addr_q,
  output logic [DW-1:0]     data_q,
  output logic [BASE_W-1:0] base_q
);
  logic host_wr;
  assign host_wr = wr_en && !busy;

  // request decode, read > write > burst
  always_comb begin
    start    = 1'b0;
    start_op = OP_RD;
    if (host_wr && wr_addr == REG_CTRL) begin
      if (wr_data[1]) begin
        start = 1'b1; start_op = OP_RD;
      end else if (wr_data[0]) begin
        start = 1'b1; start_op = OP_WR;
      end else if (wr_data[2]) begin
        start = 1'b1; start_op = OP_BURST;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      base_q <= '0;
    end else begin
      if (dat_ld) data_q <= dat_val;
      if (host_wr) begin
        case (wr_addr)
          REG_ADDR: addr_q <= wr_data[EE_AW-1:0];
          REG_DATA: data_q <= wr_data[DW-1:0];
          REG_BASE: base_q <= wr_data[BASE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (rd_addr)
        REG_CTRL: rd_data[3:0] <= {busy, act_burst, act_rd, act_wr};
        REG_ADDR: rd_data[EE_AW-1:0] <= addr_q;
        REG_DATA: rd_data[DW-1:0] <= data_q;
        default:  rd_data[BASE_W-1:0] <= base_q;
      endcase
    end
  end

  // R7: configuration frozen while an operation runs
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(base_q) && $stable(addr_q));
  // R2: read byte captured in data register
  a_r2_data_load: assert property (@(posedge clk) disable iff (rst)
    dat_ld |=> data_q == $past(dat_val));
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_loader_pkg::*;
#(
  parameter int EE_AW = 16,
  parameter int DW = 8,
  parameter int MEM_AW = 24,
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_e               start_op,
  input  logic [EE_AW-1:0]  addr_q,
  input  logic [DW-1:0]     data_q,
  input  logic [BASE_W-1:0] base_q,
  output logic              busy,
  output logic              act_rd,
  output logic              act_wr,
  output logic              act_burst,
  output logic              dat_ld,
  output logic [DW-1:0]     dat_val,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [DW-1:0]     ee_wdata,
  input  logic              ee_ack,
  input  logic [DW-1:0]     ee_rdata,
  output logic              mem_valid,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_data
);
  localparam int OFFS_W = MEM_AW - BASE_W;

  st_e              state;
  logic             fresh;
  logic [EE_AW-1:0] last;
  logic [DW-1:0]    alo;
  logic [OFFS_W-1:0] tgt;
  logic [DW-1:0]    cnt;
  logic [EE_AW-1:0] nxt;
  logic [EE_AW-1:0] bstart;

  assign nxt       = ee_addr + 1'b1;
  assign bstart    = fresh ? '0 : last + 1'b1;
  assign busy      = state != S_IDLE;
  assign act_rd    = state == S_ONE && !ee_we;
  assign act_wr    = state == S_ONE && ee_we;
  assign act_burst = busy && state != S_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      fresh     <= 1'b1;
      last      <= '0;
      alo       <= '0;
      tgt       <= '0;
      cnt       <= '0;
      ee_req    <= 1'b0;
      ee_we     <= 1'b0;
      ee_addr   <= '0;
      ee_wdata  <= '0;
      dat_ld    <= 1'b0;
      dat_val   <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      dat_ld    <= 1'b0;
      mem_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fresh  <= 1'b0;
          ee_req <= 1'b1;
          if (start_op == OP_BURST) begin
            ee_addr <= bstart;
            ee_we   <= 1'b0;
            state   <= S_ALO;
          end else begin
            ee_addr  <= addr_q;
            ee_we    <= start_op == OP_WR;
            ee_wdata <= data_q;
            state    <= S_ONE;
          end
        end
        S_ONE: if (ee_ack) begin
          ee_req <= 1'b0;
          last   <= ee_addr;
          state  <= S_IDLE;
          if (!ee_we) begin
            dat_ld  <= 1'b1;
            dat_val <= ee_rdata;
          end
        end
        default: if (ee_ack) begin
          last    <= ee_addr;
          ee_addr <= nxt;
          case (state)
            S_ALO: begin
              alo   <= ee_rdata;
              state <= S_AHI;
            end
            S_AHI: begin
              tgt   <= OFFS_W'({ee_rdata, alo});
              state <= S_CNT;
            end
            S_CNT: begin
              cnt <= ee_rdata;
              if (ee_rdata == '0) begin
                ee_req <= 1'b0;
                state  <= S_IDLE;
              end else state <= S_DAT;
            end
            default: begin
              mem_valid <= 1'b1;
              mem_addr  <= {base_q, tgt};
              mem_data  <= ee_rdata;
              tgt       <= tgt + 1'b1;
              cnt       <= cnt - 1'b1;
              if (cnt == 8'd1) state <= S_ALO;
            end
          endcase
        end
      endcase
    end
  end

  // R9: request held steady until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    ee_req && !ee_ack |=> ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata));
  // R6: every memory write lands inside the base window
  a_r6_in_window: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_addr[MEM_AW-1:OFFS_W] == base_q);
  // R3: an EEPROM write targets the host address register
  a_r3_wr_target: assert property (@(posedge clk) disable iff (rst)
    ee_req && ee_we |-> ee_addr == addr_q && ee_wdata == data_q);
  // R7: no request without busy
  a_r7_req_busy: assert property (@(posedge clk) disable iff (rst)
    ee_req |-> busy);
endmodule

// File: rtl/nvm_burst_loader.sv
module nvm_burst_loader
  import nvm_loader_pkg::*;
#(
  parameter int HW = 32,
  parameter int EE_AW = 16,
  parameter int DW = 8,
  parameter int MEM_AW = 24,
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [HW-1:0]     wr_data,
  input  logic [1:0]        rd_addr,
  output logic [HW-1:0]     rd_data,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [DW-1:0]     ee_wdata,
  input  logic              ee_ack,
  input  logic [DW-1:0]     ee_rdata,
  output logic              mem_valid,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_data
);
  logic              start, busy, act_rd, act_wr, act_burst, dat_ld;
  op_e               start_op;
  logic [EE_AW-1:0]  addr_q;
  logic [DW-1:0]     data_q, dat_val;
  logic [BASE_W-1:0] base_q;

  nvm_regs #(.HW(HW), .EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W)) regs_i (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .busy, .act_rd, .act_wr, .act_burst, .dat_ld, .dat_val,
    .start, .start_op, .addr_q, .data_q, .base_q
  );

  nvm_seq #(.EE_AW(EE_AW), .DW(DW), .MEM_AW(MEM_AW), .BASE_W(BASE_W)) seq_i (
    .clk, .rst, .start, .start_op, .addr_q, .data_q, .base_q,
    .busy, .act_rd, .act_wr, .act_burst, .dat_ld, .dat_val,
    .ee_req, .ee_we, .ee_addr, .ee_wdata, .ee_ack, .ee_rdata,
    .mem_valid, .mem_addr, .mem_data
  );

  // R4: burst and single activity never coexist
  a_r4_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act_rd, act_wr, act_burst}));
endmodule

// File: tb/nvm_burst_loader_tb.sv
module nvm_burst_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ee_req, ee_we, ee_ack;
  logic [15:0] ee_addr;
  logic [7:0]  ee_wdata, ee_rdata;
  logic        mem_valid;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  nvm_burst_loader dut_i (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .ee_req, .ee_we, .ee_addr, .ee_wdata, .ee_ack, .ee_rdata,
    .mem_valid, .mem_addr, .mem_data
  );

  // EEPROM model (256 bytes, aliased on low address byte)
  logic [7:0]  emem [256];
  int          dly = 0;
  int          wcnt = 0;
  logic        req_d = 1'b0;
  logic [15:0] acc_first = '0;
  logic [23:0] cap_addr [64];
  logic [7:0]  cap_data [64];
  int          cap_n = 0;

  always @(posedge clk) begin
    ee_ack <= 1'b0;
    req_d  <= ee_req;
    if (ee_req && !req_d) acc_first <= ee_addr;
    if (ee_req && !ee_ack) begin
      if (wcnt >= dly) begin
        ee_ack <= 1'b1;
        wcnt   <= 0;
        if (ee_we) emem[ee_addr[7:0]] <= ee_wdata;
        else ee_rdata <= emem[ee_addr[7:0]];
      end else wcnt <= wcnt + 1;
    end
    if (mem_valid && cap_n < 64) begin
      cap_addr[cap_n] <= mem_addr;
      cap_data[cap_n] <= mem_data;
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic wait_idle(output logic [31:0] c);
    for (int i = 0; i < 2000; i++) begin
      rd(2'd0, c);
      if (!c[3]) break;
    end
  endtask

  function automatic logic [23:0] tgt(input logic [8:0] b, input logic [15:0] f);
    return (24'(b) << 15) | 24'(f & 16'h7FFF);
  endfunction

  initial begin
    logic [31:0] v;
    int base_n;
    for (int i = 0; i < 256; i++) emem[i] = 8'h00;
    // burst image at 0: rec(0x8123, 3: 11 22 33), rec(0x7FFF, 2: 44 55), end
    emem[0] = 8'h23; emem[1] = 8'h81; emem[2] = 8'h03;
    emem[3] = 8'h11; emem[4] = 8'h22; emem[5] = 8'h33;
    emem[6] = 8'hFF; emem[7] = 8'h7F; emem[8] = 8'h02;
    emem[9] = 8'h44; emem[10] = 8'h55;
    // second image at 14: rec(0x0005, 1: 66), end
    emem[14] = 8'h05; emem[15] = 8'h00; emem[16] = 8'h01; emem[17] = 8'h66;
    // third image at 0x41: rec(0x0100, 1: 77), end
    emem[8'h41] = 8'h00; emem[8'h42] = 8'h01; emem[8'h43] = 8'h01; emem[8'h44] = 8'h77;
    emem[8'hFF] = 8'h99;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg reset", v, 0);
    end
    chk("R1 ee_req idle", 32'(ee_req), 0);
    chk("R1 mem_valid idle", 32'(mem_valid), 0);

    // R10 widths
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R10 addr width", v, 32'hFFFF);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R10 data width", v, 32'hFF);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R10 base width", v, 32'h1FF);

    // R4/R5/R6 first burst from address 0
    dly = 1;
    wr(2'd3, 32'h1A5);
    wr(2'd0, 32'h4);
    rd(2'd0, v); chk("R7 busy bit during burst", v & 32'hC, 32'hC);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h2);
    wait_idle(v);
    chk("R4 burst bit clears", v, 0);
    rd(2'd3, v); chk("R7 base write ignored while busy", v, 32'h1A5);
    chk("R5 first burst at 0", 32'(acc_first), 0);
    chk("R4 write count", cap_n, 5);
    chk("R6 addr 0", 32'(cap_addr[0]), 32'(tgt(9'h1A5, 16'h8123)));
    chk("R6 addr 2", 32'(cap_addr[2]), 32'(tgt(9'h1A5, 16'h8125)));
    chk("R6 window wrap hi", 32'(cap_addr[3]), 32'(tgt(9'h1A5, 16'h7FFF)));
    chk("R6 window wrap lo", 32'(cap_addr[4]), 32'(tgt(9'h1A5, 16'h0000)));
    chk("R4 data 1", 32'(cap_data[1]), 32'h22);
    chk("R4 data 4", 32'(cap_data[4]), 32'h55);

    // R5 chained burst resumes at 14
    dly = 0;
    wr(2'd3, 32'h2);
    wr(2'd0, 32'h4);
    wait_idle(v);
    chk("R5 resume after burst", 32'(acc_first), 14);
    chk("R6 second burst addr", 32'(cap_addr[5]), 32'(tgt(9'h2, 16'h0005)));
    chk("R4 second burst data", 32'(cap_data[5]), 32'h66);

    // R2 single read
    dly = 3;
    wr(2'd1, 32'h3);
    wr(2'd0, 32'h2);
    rd(2'd0, v); chk("R2 read bit while active", v & 32'h2, 32'h2);
    wait_idle(v);
    chk("R2 read bit clears", v, 0);
    rd(2'd2, v); chk("R2 read data", v, 32'h11);

    // R3 single write
    dly = 2;
    wr(2'd1, 32'h40);
    wr(2'd2, 32'h5A);
    wr(2'd0, 32'h1);
    wait_idle(v);
    chk("R3 write bit clears", v, 0);
    chk("R3 eeprom content", 32'(emem[8'h40]), 32'h5A);

    // R5 burst after single write starts at 0x41
    base_n = 3;
    wr(2'd3, 32'(base_n));
    wr(2'd0, 32'h4);
    wait_idle(v);
    chk("R5 resume after single", 32'(acc_first), 32'h41);
    chk("R6 third burst addr", 32'(cap_addr[6]), 32'(tgt(9'(base_n), 16'h0100)));

    // R5 wrap modulo 2^16
    dly = 0;
    wr(2'd1, 32'hFFFF);
    wr(2'd0, 32'h2);
    wait_idle(v);
    rd(2'd2, v); chk("R2 read at top address", v, 32'h99);
    wr(2'd0, 32'h4);
    wait_idle(v);
    chk("R5 address wrap", 32'(acc_first), 0);
    chk("R4 wrap burst count", cap_n, 12);

    // R8 priority read over write over burst
    wr(2'd1, 32'h3);
    wr(2'd2, 32'h00);
    wr(2'd0, 32'h7);
    wait_idle(v);
    rd(2'd2, v); chk("R8 read wins data", v, 32'h11);
    chk("R8 no write done", 32'(emem[3]), 32'h11);
    chk("R8 no burst done", cap_n, 12);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule